// File: doc/BRIEF.md
# Strobed Watchdog Timer With Write-Lock

This block is a watchdog for a host processor. A down counter is preloaded with a 6-bit timeout value and steps down by one on each pulse of a slow periodic tick, for example a 32 Hz enable derived from a crystal oscillator. At that rate each count is 31.25 ms. The host must restart the countdown before it reaches zero. If the count runs out, a sticky watchdog flag is raised. An interrupt request follows the flag when the interrupt enable is high. Reading the flag clears it and clears the interrupt with it.

Software reaches the block through a single register-style write port. Each written word holds three parts:
- a kick bit, which reloads the counter;
- a lock bit, which guards the timeout field;
- the timeout field itself.

Because the kick and the lock are separate bits, a routine that only services the watchdog can write with the lock set. It then restarts the count without any chance of corrupting the timeout. A timeout of zero switches the watchdog off. At reset the timeout register and the counter both take a parameterised initial value, and counting starts at once.

Top module: `wdt_core`

## Requirements
- R1: After synchronous reset, `count_o` equals the `INIT_TIMEOUT` parameter (default 4), and `flag_o` and `irq_o` are 0. Counting starts in the first cycle after reset.
- R2: While the stored timeout is nonzero and the count is nonzero, each cycle with `tick_i` high and no kick lowers `count_o` by exactly one. Without a tick the count does not change.
- R3: A write with bit 7 (kick) set reloads the counter with the effective timeout. The effective timeout is the new field if this write updates it, otherwise the stored value. A kick wins over a tick in the same cycle.
- R4: Bits 5..0 of a written word replace the stored timeout only when bit 6 (lock) of that same word is 0. When bit 6 is 1 the field is ignored.
- R5: A write that updates the timeout without setting the kick bit leaves the running count unchanged. The new value takes effect at the next kick.
- R6: On the tick that moves the count from 1 to 0, `flag_o` rises at that same clock edge. The counter then stays at 0 until a kick. Further ticks do not raise the flag again after it has been cleared.
- R7: `irq_o` is high exactly when `flag_o` is high and `irq_en_i` is high.
- R8: A cycle with `flag_rd_i` high clears `flag_o` and therefore `irq_o`. If an expiry happens in the same cycle, the flag is set instead.
- R9: While the stored timeout is 0, the counter does not change on ticks and the flag never rises.
- R10: If a kick always arrives before the count reaches zero, the flag and the interrupt never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Single-cycle timebase enable, one pulse per count period |
| wr_i | input | 1 | Write strobe for the control word |
| wdata_i | input | 8 | Control word: bit 7 kick, bit 6 lock, bits 5..0 timeout |
| flag_rd_i | input | 1 | Flag-read strobe; clears the flag |
| irq_en_i | input | 1 | Watchdog interrupt enable |
| count_o | output | 6 | Current counter value |
| flag_o | output | 1 | Sticky watchdog expiry flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the same-cycle collisions. In one, a flag read meets the very tick that expires the counter. In the other, a kick meets a tick. The stimulus first walks the count down to exactly 1 with spaced ticks, then drives the expiring tick and the read strobe together, and expects the flag to remain set. The bench also loads a fresh timeout and drives a kick and a tick in one cycle, and expects the full reload value rather than one less. Locked writes are detected only at the ports: a later kick is expected to reload the old timeout, not the value carried by the locked write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    parameter int TOUT_W = 6;
    localparam int WORD_W   = TOUT_W + 2;
    localparam int KICK_POS = TOUT_W + 1;
    localparam int LOCK_POS = TOUT_W;

    typedef logic [TOUT_W-1:0] tout_t;

    typedef struct packed {
        logic  kick;
        logic  lock;
        tout_t tout;
    } ctl_word_t;

    function automatic ctl_word_t decode_word(input logic [WORD_W-1:0] w);
        return ctl_word_t'(w);
    endfunction

    function automatic logic on_last_count(input tout_t c);
        return c == tout_t'(1);
    endfunction
endpackage

// File: rtl/wdt_timeout_reg.sv
module wdt_timeout_reg
    import wdt_pkg::*;
#(
    parameter int INIT_TIMEOUT = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  ctl_word_t word,
    output tout_t     tout_q,
    output tout_t     tout_eff
);
    always_comb begin
        tout_eff = tout_q;
        if (wr && !word.lock) tout_eff = word.tout;
    end

    always_ff @(posedge clk) begin
        if (rst) tout_q <= tout_t'(INIT_TIMEOUT);
        else     tout_q <= tout_eff;
    end

    AST_LOCKED_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (wr && word.lock) |=> (tout_q == $past(tout_q))); // R4
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
    import wdt_pkg::*;
#(
    parameter int INIT_TIMEOUT = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  load,
    input  tout_t load_val,
    input  logic  enable,
    output tout_t cnt_q,
    output logic  expire
);
    logic step;

    always_comb begin
        step   = tick && enable && !load && (cnt_q != '0);
        expire = step && on_last_count(cnt_q);
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= tout_t'(INIT_TIMEOUT);
        else if (load) cnt_q <= load_val;
        else if (step) cnt_q <= cnt_q - tout_t'(1);
    end

    AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val))); // R3
    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ((cnt_q == '0) && !load) |=> (cnt_q == '0)); // R6
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt_q)); // R2
    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!enable && !load) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/wdt_flag_unit.sv
module wdt_flag_unit (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic flag_q,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)      flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    assign irq = flag_q && irq_en;

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag_q); // R8
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        set |=> flag_q); // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag_q); // R7
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int INIT_TIMEOUT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              flag_rd_i,
    input  logic              irq_en_i,
    output logic [TOUT_W-1:0] count_o,
    output logic              flag_o,
    output logic              irq_o
);
    ctl_word_t word;
    tout_t     tout_q, tout_eff, cnt_q;
    logic      expire, kick;

    assign word = decode_word(wdata_i);
    assign kick = wr_i && word.kick;

    wdt_timeout_reg #(.INIT_TIMEOUT(INIT_TIMEOUT)) u_tout (
        .clk(clk), .rst(rst), .wr(wr_i), .word(word),
        .tout_q(tout_q), .tout_eff(tout_eff)
    );

    wdt_down_counter #(.INIT_TIMEOUT(INIT_TIMEOUT)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick_i), .load(kick),
        .load_val(tout_eff), .enable(tout_q != '0),
        .cnt_q(cnt_q), .expire(expire)
    );

    wdt_flag_unit u_flag (
        .clk(clk), .rst(rst), .set(expire), .clr(flag_rd_i),
        .irq_en(irq_en_i), .flag_q(flag_o), .irq(irq_o)
    );

    assign count_o = cnt_q;

    AST_DISABLED_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        ((tout_q == '0) && !flag_o) |=> !flag_o); // R9
    AST_FLAG_NEEDS_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> (count_o == '0)); // R6
endmodule

// File: tb/sim_wdt_core.sv
module sim_wdt_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0, wr_i = 1'b0, flag_rd_i = 1'b0, irq_en_i = 1'b1;
    logic [7:0] wdata_i = '0;
    logic [5:0] count_o;
    logic       flag_o, irq_o;

    always #2.5 clk = ~clk;

    wdt_core u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i), .wr_i(wr_i), .wdata_i(wdata_i),
        .flag_rd_i(flag_rd_i), .irq_en_i(irq_en_i),
        .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    int    n_cmp = 0, n_bad = 0;
    bit    done = 0;
    int    q_cnt[$];
    bit    q_flag[$], q_irq[$];
    string q_tag[$];

    int m_tout, m_cnt;
    bit m_flag;

    function automatic logic [7:0] mk(bit kick, bit lock, int t);
        return {kick, lock, t[5:0]};
    endfunction

    // driver: apply one cycle of stimulus, predict from the requirements
    task automatic cyc(bit tk, bit wr, logic [7:0] d, bit rd, string tag);
        int eff;
        bit set;
        @(negedge clk);
        tick_i = tk; wr_i = wr; wdata_i = d; flag_rd_i = rd;
        eff = (wr && !d[6]) ? int'(d[5:0]) : m_tout;
        set = 0;
        if (wr && d[7]) m_cnt = eff;
        else if (tk && m_tout != 0 && m_cnt != 0) begin
            set = (m_cnt == 1);
            m_cnt = m_cnt - 1;
        end
        if (set) m_flag = 1;
        else if (rd) m_flag = 0;
        m_tout = eff;
        q_cnt.push_back(m_cnt);
        q_flag.push_back(m_flag);
        q_irq.push_back(m_flag && irq_en_i);
        q_tag.push_back(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, tag);
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1, 0, 8'h00, 0, tag);
            cyc(0, 0, 8'h00, 0, tag);
        end
    endtask

    // monitor: pop and compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_tag.size() > 0) begin
                int  ec;
                bit  ef, ei;
                string t;
                ec = q_cnt.pop_front(); ef = q_flag.pop_front();
                ei = q_irq.pop_front(); t = q_tag.pop_front();
                n_cmp++;
                if (int'(count_o) != ec || flag_o !== ef || irq_o !== ei) begin
                    n_bad++;
                    $display("FAIL %s: cnt=%0d flag=%0b irq=%0b expected cnt=%0d flag=%0b irq=%0b",
                             t, count_o, flag_o, irq_o, ec, ef, ei);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_tout = 4; m_cnt = 4; m_flag = 0;
        idle(2, "R1 reset state");
        // countdown and expiry
        ticks(3, "R2 tick decrement");
        cyc(1, 0, 8'h00, 0, "R6 expiry sets flag");
        cyc(0, 0, 8'h00, 0, "R7 irq with flag and enable");
        ticks(2, "R6 hold at zero");
        cyc(0, 0, 8'h00, 1, "R8 read clears flag");
        ticks(3, "R6 no re-flag at zero");
        // locked write ignored, kick reloads stored value
        cyc(0, 1, mk(0, 1, 10), 0, "R4 locked write");
        cyc(0, 1, mk(1, 1, 33), 0, "R4 kick reloads old timeout");
        // unlocked write without kick
        ticks(1, "R2 tick decrement");
        cyc(0, 1, mk(0, 0, 10), 0, "R5 write keeps count");
        ticks(1, "R5 count continues");
        cyc(1, 1, mk(1, 1, 0), 0, "R3 kick beats tick");
        // kick before expiry, repeatedly
        for (int k = 0; k < 4; k++) begin
            ticks(8, "R10 serviced watchdog");
            cyc(0, 1, mk(1, 1, 0), 0, "R10 kick");
        end
        // expiry with interrupt disabled
        @(negedge clk); irq_en_i = 1'b0;
        ticks(10, "R7 irq masked");
        cyc(0, 0, 8'h00, 0, "R7 flag without irq");
        @(negedge clk); irq_en_i = 1'b1;
        cyc(0, 0, 8'h00, 0, "R7 irq after enable");
        cyc(0, 0, 8'h00, 1, "R8 read clears");
        // read and expiry in the same cycle
        cyc(0, 1, mk(1, 0, 3), 0, "R3 kick with new value");
        ticks(2, "R2 tick decrement");
        cyc(1, 0, 8'h00, 1, "R8 set beats clear");
        idle(1, "R8 flag kept");
        cyc(0, 0, 8'h00, 1, "R8 read clears");
        // disable by zero timeout
        cyc(0, 1, mk(1, 0, 5), 0, "R3 reload");
        ticks(1, "R2 tick decrement");
        cyc(0, 1, mk(0, 0, 0), 0, "R9 zero timeout written");
        ticks(6, "R9 frozen count");
        cyc(0, 1, mk(1, 0, 0), 0, "R9 kick to zero");
        ticks(4, "R9 no flag when disabled");
        idle(3, "R9 no flag when disabled");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule